// File: doc/BRIEF.md
# TPM Locality Claim Sequencer

This block runs the start-up handshake with a TPM that exposes the FIFO register interface. When `start` is pulsed it issues a fixed series of register transactions on a simple request port. A transaction master, which does the serial framing, turns each request into a bus cycle and returns read data one byte per `rsp_valid` pulse. The sequencer first fetches the identity word. It then inspects the access register. If a locality is already active, it releases that locality and looks again. It then asks for locality zero and confirms the grant. Next it checks that the interface family field in the status register names a TPM2 device, and finally it reads the revision byte.

The results stay on the outputs until the next start: the vendor and device identifiers, the revision, a `done` flag and a two-bit error code that names the first check that failed. A failed check ends the series at once, and no further requests are issued. The states are ST_IDLE, ST_GET_ID, ST_PEEK_ACC, ST_DROP_LOC, ST_RECHECK_ACC, ST_ASK_LOC, ST_CONFIRM_LOC, ST_GET_STS and ST_GET_REV.

The transitions are:
- start moves IDLE to GET_ID.
- ID complete moves to PEEK_ACC.
- From PEEK_ACC, an active locality moves to DROP_LOC. A clean value moves to ASK_LOC. Anything else moves to IDLE with error 1.
- DROP_LOC moves to RECHECK_ACC.
- From RECHECK_ACC, a clean value moves to ASK_LOC, and anything else moves to IDLE with error 1.
- ASK_LOC moves to CONFIRM_LOC.
- From CONFIRM_LOC, a granted claim moves to GET_STS, and anything else moves to IDLE with error 2.
- From GET_STS, the right family moves to GET_REV, and anything else moves to IDLE with error 3.
- GET_REV moves to IDLE with error 0.

Top module: `tpm_locality_seq`

## Requirements
- R1: After start, the first request reads 4 bytes at address 0xF00. The first returned byte is bits 7:0 of the word (little-endian). `vendor_id` is word bits 15:0 and `device_id` is word bits 31:16.
- R2: The second request reads 1 byte at address 0x000 (access register). If bit 5 (locality active) of that byte is set, the block writes the single byte 0x20 to 0x000 and reads 0x000 again. Otherwise it issues no release write.
- R3: The access value that is checked is the reread value if a release took place, and the first read otherwise. With bit 0 (establishment) masked off, this value must equal 0x80 (bit 7, valid). Otherwise `err_code` becomes 1 and no further request is issued.
- R4: After the reset check passes, the block writes the byte 0x02 (bit 1, request use) to 0x000 and reads 0x000 once more. With bit 0 masked, the value must equal 0xA0, or `err_code` becomes 2 and the series ends.
- R5: Next the block reads 4 bytes at 0x018. Bits 27:26 must equal 2'b01, or `err_code` becomes 3 and the series ends.
- R6: Last, the block reads 1 byte at 0xF04. This byte becomes `revision`, and `err_code` is 0. On any failure `revision` stays 0.
- R7: When the series ends, `done` rises and `busy` is low. A start taken in idle clears `done`, `err_code`, the identifiers and `revision`. Without a start, all outputs hold their values.
- R8: A start pulse while `busy` is high has no effect on the request series or the results.
- R9: Request fields stay stable while `req_valid` is high. A read completes on its `req_len`-th `rsp_valid`, and a write completes on a single `rsp_valid`. `req_valid` is low for the cycle after each completion.
- R10: After reset, `busy`, `done` and `req_valid` are low, and `err_code`, the identifiers and `revision` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the handshake |
| busy | output | 1 | Series in progress |
| done | output | 1 | Series finished (held) |
| err_code | output | 2 | 0 ok, 1 bad reset state, 2 claim refused, 3 wrong family |
| vendor_id | output | 16 | Identity word bits 15:0 |
| device_id | output | 16 | Identity word bits 31:16 |
| revision | output | 8 | Revision byte |
| req_valid | output | 1 | Register request present |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 12 | Register address |
| req_len | output | 3 | Byte count, 1 to 4 |
| req_wdata | output | 32 | Write data, byte in bits 7:0 |
| rsp_valid | input | 1 | One read byte, or write acknowledge |
| rsp_byte | input | 8 | Read data byte, least significant first |

## Verification
A start sampled at a clock edge shows `req_valid` after that same edge. Every later request appears one edge after the previous one completes. The completion edge, meaning the one that samples the final response byte, also updates `done`, `err_code`, the identifiers and the revision. `req_valid` is then low for exactly the following cycle. The bench drives and samples on the falling edge. It waits for `done` with a bounded loop before reading the results, and it checks the one-cycle request gap at the falling edge right after the byte that completes each transaction. The full request log is compared with a list that a bench function computes from the register values of each scenario. The responder inserts random delays of 0 to 2 cycles before each byte, so the checks do not depend on any fixed transaction length.

// File: rtl/tpm_lc_pkg.sv
`timescale 1ns/1ps
package tpm_lc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 3;
    localparam int NBYTES = DATA_W / 8;

    localparam logic [ADDR_W-1:0] A_ACCESS = 12'h000;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h018;
    localparam logic [ADDR_W-1:0] A_IDENT  = 12'hF00;
    localparam logic [ADDR_W-1:0] A_REVID  = 12'hF04;

    localparam int ACC_VALID_BIT  = 7;
    localparam int ACC_ACTIVE_BIT = 5;
    localparam int ACC_ASK_BIT    = 1;
    localparam int ACC_ESTAB_BIT  = 0;
    localparam int FAM_LSB        = 26;
    localparam logic [1:0] FAM_TPM2 = 2'b01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GET_ID,
        ST_PEEK_ACC,
        ST_DROP_LOC,
        ST_RECHECK_ACC,
        ST_ASK_LOC,
        ST_CONFIRM_LOC,
        ST_GET_STS,
        ST_GET_REV
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_RESET  = 2'd1,
        ERR_CLAIM  = 2'd2,
        ERR_FAMILY = 2'd3
    } seq_err_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

endpackage

// File: rtl/tpm_lc_reqmap.sv
`timescale 1ns/1ps
module tpm_lc_reqmap
    import tpm_lc_pkg::*;
(
    input  seq_state_e state,
    output bus_req_t   req
);

    localparam logic [DATA_W-1:0] REL_BYTE = DATA_W'(1) << ACC_ACTIVE_BIT;
    localparam logic [DATA_W-1:0] ASK_BYTE = DATA_W'(1) << ACC_ASK_BIT;
    localparam logic [LEN_W-1:0]  ONE      = LEN_W'(1);
    localparam logic [LEN_W-1:0]  WORD     = LEN_W'(NBYTES);

    always_comb begin
        req = '0;
        unique case (state)
            ST_IDLE:        req = '0;
            ST_GET_ID:      req = '{write: 1'b0, addr: A_IDENT,  len: WORD, wdata: '0};
            ST_PEEK_ACC:    req = '{write: 1'b0, addr: A_ACCESS, len: ONE,  wdata: '0};
            ST_DROP_LOC:    req = '{write: 1'b1, addr: A_ACCESS, len: ONE,  wdata: REL_BYTE};
            ST_RECHECK_ACC: req = '{write: 1'b0, addr: A_ACCESS, len: ONE,  wdata: '0};
            ST_ASK_LOC:     req = '{write: 1'b1, addr: A_ACCESS, len: ONE,  wdata: ASK_BYTE};
            ST_CONFIRM_LOC: req = '{write: 1'b0, addr: A_ACCESS, len: ONE,  wdata: '0};
            ST_GET_STS:     req = '{write: 1'b0, addr: A_STATUS, len: WORD, wdata: '0};
            ST_GET_REV:     req = '{write: 1'b0, addr: A_REVID,  len: ONE,  wdata: '0};
            default:        req = '0;
        endcase
    end

endmodule

// File: rtl/tpm_lc_collect.sv
`timescale 1ns/1ps
module tpm_lc_collect #(
    parameter int BYTES = 4,
    parameter int LEN_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               is_write,
    input  logic [LEN_W-1:0]   len,
    input  logic               rsp_valid,
    input  logic [7:0]         rsp_byte,
    output logic               done,
    output logic [8*BYTES-1:0] word
);

    logic [LEN_W-1:0] cnt;
    logic             take;
    logic             take_rd;

    assign take    = active && rsp_valid;
    assign take_rd = take && !is_write;
    assign done    = take && (is_write || (cnt == len - LEN_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (take_rd) begin
            cnt <= cnt + LEN_W'(1);
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        logic       hit;

        assign hit = take_rd && (cnt == LEN_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (!active) begin
                lane_q <= '0;
            end else if (hit) begin
                lane_q <= rsp_byte;
            end
        end

        assign word[8*g +: 8] = hit ? rsp_byte : lane_q;
    end

endmodule

// File: rtl/tpm_lc_judge.sv
`timescale 1ns/1ps
module tpm_lc_judge
    import tpm_lc_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output logic              loc_active,
    output logic              reset_ok,
    output logic              claim_ok,
    output logic              family_ok
);

    localparam logic [7:0] ESTAB_M = 8'(1) << ACC_ESTAB_BIT;
    localparam logic [7:0] VALID_M = 8'(1) << ACC_VALID_BIT;
    localparam logic [7:0] ACTV_M  = 8'(1) << ACC_ACTIVE_BIT;

    logic [7:0] acc_masked;

    assign acc_masked = word[7:0] & ~ESTAB_M;
    assign loc_active = word[ACC_ACTIVE_BIT];
    assign reset_ok   = (acc_masked == VALID_M);
    assign claim_ok   = (acc_masked == (VALID_M | ACTV_M));
    assign family_ok  = (word[FAM_LSB +: 2] == FAM_TPM2);

endmodule

// File: rtl/tpm_locality_seq.sv
`timescale 1ns/1ps
module tpm_locality_seq
    import tpm_lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [15:0]       vendor_id,
    output logic [15:0]       device_id,
    output logic [7:0]        revision,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_byte
);

    seq_state_e        state, nxt;
    seq_err_e          fail_code;
    logic              finish;
    logic              settle;
    logic              xfer_done;
    logic [DATA_W-1:0] xfer_word;
    bus_req_t          req;
    logic              loc_active, reset_ok, claim_ok, family_ok;

    tpm_lc_reqmap u_map (
        .state (state),
        .req   (req)
    );

    assign busy      = (state != ST_IDLE);
    assign req_valid = busy && !settle;
    assign req_write = req.write;
    assign req_addr  = req.addr;
    assign req_len   = req.len;
    assign req_wdata = req.wdata;

    tpm_lc_collect #(
        .BYTES (NBYTES),
        .LEN_W (LEN_W)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (req_valid),
        .is_write  (req.write),
        .len       (req.len),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte),
        .done      (xfer_done),
        .word      (xfer_word)
    );

    tpm_lc_judge u_judge (
        .word       (xfer_word),
        .loc_active (loc_active),
        .reset_ok   (reset_ok),
        .claim_ok   (claim_ok),
        .family_ok  (family_ok)
    );

    // Next-state selection
    always_comb begin
        nxt       = state;
        finish    = 1'b0;
        fail_code = ERR_NONE;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_GET_ID;
            end
            ST_GET_ID: begin
                if (xfer_done) nxt = ST_PEEK_ACC;
            end
            ST_PEEK_ACC: begin
                if (xfer_done) begin
                    if (loc_active) begin
                        nxt = ST_DROP_LOC;
                    end else if (reset_ok) begin
                        nxt = ST_ASK_LOC;
                    end else begin
                        nxt       = ST_IDLE;
                        finish    = 1'b1;
                        fail_code = ERR_RESET;
                    end
                end
            end
            ST_DROP_LOC: begin
                if (xfer_done) nxt = ST_RECHECK_ACC;
            end
            ST_RECHECK_ACC: begin
                if (xfer_done) begin
                    if (reset_ok) begin
                        nxt = ST_ASK_LOC;
                    end else begin
                        nxt       = ST_IDLE;
                        finish    = 1'b1;
                        fail_code = ERR_RESET;
                    end
                end
            end
            ST_ASK_LOC: begin
                if (xfer_done) nxt = ST_CONFIRM_LOC;
            end
            ST_CONFIRM_LOC: begin
                if (xfer_done) begin
                    if (claim_ok) begin
                        nxt = ST_GET_STS;
                    end else begin
                        nxt       = ST_IDLE;
                        finish    = 1'b1;
                        fail_code = ERR_CLAIM;
                    end
                end
            end
            ST_GET_STS: begin
                if (xfer_done) begin
                    if (family_ok) begin
                        nxt = ST_GET_REV;
                    end else begin
                        nxt       = ST_IDLE;
                        finish    = 1'b1;
                        fail_code = ERR_FAMILY;
                    end
                end
            end
            ST_GET_REV: begin
                if (xfer_done) begin
                    nxt    = ST_IDLE;
                    finish = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            settle <= 1'b0;
        end else begin
            state  <= nxt;
            settle <= xfer_done;
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err_code  <= ERR_NONE;
            vendor_id <= '0;
            device_id <= '0;
            revision  <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                done      <= 1'b0;
                err_code  <= ERR_NONE;
                vendor_id <= '0;
                device_id <= '0;
                revision  <= '0;
            end
        end else if (xfer_done) begin
            if (state == ST_GET_ID) begin
                vendor_id <= xfer_word[15:0];
                device_id <= xfer_word[31:16];
            end
            if (state == ST_GET_REV) begin
                revision <= xfer_word[7:0];
            end
            if (finish) begin
                done     <= 1'b1;
                err_code <= fail_code;
            end
        end
    end

endmodule

// File: rtl/tpm_locality_seq_chk.sv
`timescale 1ns/1ps
module tpm_locality_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [1:0]  err_code,
    input logic [15:0] vendor_id,
    input logic [7:0]  revision,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [2:0]  req_len,
    input logic [31:0] req_wdata,
    input logic        xfer_done
);

    p_gap_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !req_valid);

    p_fields_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xfer_done) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_write) && $stable(req_len)));

    p_write_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_len == 3'd1 && req_addr == 12'h000
            && (req_wdata == 32'h20 || req_wdata == 32'h02)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!done && err_code == 2'd0 && busy));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !busy) |=> ($stable(done) && $stable(err_code)
                               && $stable(vendor_id) && $stable(revision)));

    p_fail_no_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 2'd0) |-> revision == 8'h00);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

endmodule

bind tpm_locality_seq tpm_locality_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err_code  (err_code),
    .vendor_id (vendor_id),
    .revision  (revision),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_wdata (req_wdata),
    .xfer_done (xfer_done)
);

// File: tb/sim_tpm_locality_seq.sv
`timescale 1ns/1ps
module sim_tpm_locality_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [1:0]  err_code;
    logic [15:0] vendor_id, device_id;
    logic [7:0]  revision;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [2:0]  req_len;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_byte = 8'h00;

    always #4 clk = ~clk;

    tpm_locality_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .err_code(err_code), .vendor_id(vendor_id), .device_id(device_id),
        .revision(revision), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Register model of the device
    logic [31:0] m_ident, m_sts;
    logic [7:0]  m_acc0, m_accrel, m_accclaim, m_rid;
    int          acc_phase;

    logic [23:0] log_q [0:15];
    int          log_n;
    logic [23:0] exp_q [0:15];
    int          exp_n;
    logic [1:0]  exp_err;

    function automatic logic [31:0] reg_val(input logic [11:0] a);
        case (a)
            12'h000: return (acc_phase == 0) ? {24'h0, m_acc0} :
                            (acc_phase == 1) ? {24'h0, m_accrel} : {24'h0, m_accclaim};
            12'h018: return m_sts;
            12'hF00: return m_ident;
            12'hF04: return {24'h0, m_rid};
            default: return 32'hDEADBEEF;
        endcase
    endfunction

    // Responder: latches a request, returns bytes with random spacing
    logic        r_busy = 1'b0, r_w = 1'b0, r_gapchk = 1'b0;
    logic [2:0]  r_len = 3'd0;
    logic [31:0] r_word = 32'h0;
    int          r_idx = 0, r_wait = 0;

    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (!rst_n) begin
            r_busy   = 1'b0;
            r_gapchk = 1'b0;
        end else begin
            if (r_gapchk) begin
                chk("R9 request low after completion", {31'h0, req_valid}, 32'h0);
                r_gapchk = 1'b0;
            end
            if (!r_busy) begin
                if (req_valid) begin
                    r_w    = req_write;
                    r_len  = req_len;
                    r_word = req_write ? 32'h0 : reg_val(req_addr);
                    if (log_n < 16)
                        log_q[log_n] = {req_write, req_len, req_write ? req_wdata[7:0] : 8'h00, req_addr};
                    log_n++;
                    if (req_write && req_wdata[7:0] == 8'h20) acc_phase = 1;
                    if (req_write && req_wdata[7:0] == 8'h02) acc_phase = 2;
                    r_idx  = 0;
                    r_wait = $urandom_range(0, 2);
                    r_busy = 1'b1;
                end
            end else if (r_wait != 0) begin
                r_wait--;
            end else begin
                rsp_valid = 1'b1;
                rsp_byte  = r_w ? 8'h00 : r_word[8*r_idx +: 8];
                r_idx++;
                r_wait = $urandom_range(0, 2);
                if (r_w || r_idx == int'(r_len)) begin
                    r_busy   = 1'b0;
                    r_gapchk = 1'b1;
                end
            end
        end
    end

    task automatic push(input logic w, input logic [2:0] len, input logic [7:0] wd, input logic [11:0] a);
        exp_q[exp_n] = {w, len, wd, a};
        exp_n++;
    endtask

    // Expected request list and error from the requirements
    task automatic build_expect();
        logic [7:0] v;
        exp_n = 0;
        exp_err = 2'd0;
        push(1'b0, 3'd4, 8'h00, 12'hF00);
        push(1'b0, 3'd1, 8'h00, 12'h000);
        v = m_acc0;
        if (m_acc0[5]) begin
            push(1'b1, 3'd1, 8'h20, 12'h000);
            push(1'b0, 3'd1, 8'h00, 12'h000);
            v = m_accrel;
        end
        if ((v & 8'hFE) != 8'h80) begin
            exp_err = 2'd1;
        end else begin
            push(1'b1, 3'd1, 8'h02, 12'h000);
            push(1'b0, 3'd1, 8'h00, 12'h000);
            if ((m_accclaim & 8'hFE) != 8'hA0) begin
                exp_err = 2'd2;
            end else begin
                push(1'b0, 3'd4, 8'h00, 12'h018);
                if (m_sts[27:26] != 2'b01) exp_err = 2'd3;
                else push(1'b0, 3'd1, 8'h00, 12'hF04);
            end
        end
    endtask

    task automatic run_scenario(input bit double_start);
        int w;
        string seq_tag, err_tag;
        logic [1:0]  h_err;
        logic [15:0] h_vid;
        logic [7:0]  h_rev;
        build_expect();
        acc_phase = 0;
        log_n = 0;
        seq_tag = double_start ? "R8 request list with extra start" : "R2 request list";
        case (exp_err)
            2'd0: err_tag = "R6 error code";
            2'd1: err_tag = "R3 error code";
            2'd2: err_tag = "R4 error code";
            default: err_tag = "R5 error code";
        endcase
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (double_start) begin
            repeat (2) @(negedge clk);
            chk("R8 busy at extra start", {31'h0, busy}, 32'h1);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        w = 0;
        while (!done && w < 2000) begin
            @(negedge clk);
            w++;
        end
        chk("R7 done raised", {31'h0, done}, 32'h1);
        chk("R7 busy low at end", {31'h0, busy}, 32'h0);
        h_err = err_code;
        h_vid = vendor_id;
        h_rev = revision;
        repeat (12) @(negedge clk);
        chk("R7 error held", {30'h0, err_code}, {30'h0, h_err});
        chk("R7 vendor held", {16'h0, vendor_id}, {16'h0, h_vid});
        chk("R7 revision held", {24'h0, revision}, {24'h0, h_rev});
        chk(seq_tag, log_n, exp_n);
        for (int i = 0; i < exp_n && i < 16; i++)
            chk(seq_tag, {8'h0, log_q[i]}, {8'h0, exp_q[i]});
        chk(err_tag, {30'h0, err_code}, {30'h0, exp_err});
        chk("R1 vendor id", {16'h0, vendor_id}, {16'h0, m_ident[15:0]});
        chk("R1 device id", {16'h0, device_id}, {16'h0, m_ident[31:16]});
        chk("R6 revision", {24'h0, revision}, (exp_err == 2'd0) ? {24'h0, m_rid} : 32'h0);
    endtask

    task automatic set_regs(input logic [7:0] a0, input logic [7:0] ar, input logic [7:0] ac,
                            input logic [1:0] fam);
        m_ident    = $urandom;
        m_sts      = $urandom;
        m_sts[27:26] = fam;
        m_rid      = 8'($urandom);
        m_acc0     = a0;
        m_accrel   = ar;
        m_accclaim = ac;
    endtask

    function automatic logic [7:0] pick_acc(input logic [7:0] good);
        case ($urandom_range(0, 4))
            0: return good;
            1: return good | 8'h01;
            2: return 8'hA0;
            3: return 8'h80;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd7213));
        m_ident = 32'h0; m_sts = 32'h0; m_rid = 8'h0;
        m_acc0 = 8'h0; m_accrel = 8'h0; m_accclaim = 8'h0;
        acc_phase = 0; log_n = 0; exp_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy after reset", {31'h0, busy}, 32'h0);
        chk("R10 done after reset", {31'h0, done}, 32'h0);
        chk("R10 req_valid after reset", {31'h0, req_valid}, 32'h0);
        chk("R10 outputs after reset", {err_code, vendor_id, revision, 6'h0}, 32'h0);
        chk("R10 device after reset", {16'h0, device_id}, 32'h0);

        // Directed corner cases
        set_regs(8'h80, 8'h00, 8'hA0, 2'b01); run_scenario(1'b0); // clean claim
        set_regs(8'h81, 8'h00, 8'hA1, 2'b01); run_scenario(1'b0); // establishment bit ignored
        set_regs(8'hA0, 8'h80, 8'hA0, 2'b01); run_scenario(1'b0); // release then claim
        set_regs(8'hA1, 8'hA0, 8'hA0, 2'b01); run_scenario(1'b0); // release refused: R3
        set_regs(8'h00, 8'h80, 8'hA0, 2'b01); run_scenario(1'b0); // not valid: R3
        set_regs(8'h80, 8'h00, 8'h80, 2'b01); run_scenario(1'b0); // claim refused: R4
        set_regs(8'h80, 8'h00, 8'hA0, 2'b10); run_scenario(1'b0); // wrong family: R5
        set_regs(8'h80, 8'h00, 8'hA0, 2'b00); run_scenario(1'b0); // wrong family: R5
        set_regs(8'h80, 8'h00, 8'hA0, 2'b01); run_scenario(1'b1); // extra start: R8

        // Random scenarios
        for (int k = 0; k < 24; k++) begin
            logic [1:0] fam;
            fam = ($urandom_range(0, 2) != 0) ? 2'b01 : 2'($urandom);
            set_regs(pick_acc(8'h80), pick_acc(8'h80), pick_acc(8'hA0), fam);
            run_scenario(k % 6 == 5);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule